// File: doc/BRIEF.md
# Phase-Programmable Clock Pattern Generator

This block produces a set of slow, 50%-duty sampling clocks without using a PLL. Each clock is built as an ordinary data pattern on a fast fabric clock that runs eight times faster than the output clocks. In every fast cycle, each channel emits a two-bit word for a double-data-rate output register. Bit 0 is the slot driven on the rising edge and bit 1 is the slot driven on the following falling edge. One output period therefore holds sixteen half-cycle slots. Each channel's waveform is delayed against the reference frame by a whole number of those slots, set by its own four-bit phase value.

A frame strobe marks the reference clock edge. The strobe sets the slot position back to the start of the frame, and it is the only point at which new phase values are accepted. A channel that starts out garbled, or that has just been given a new phase, therefore produces a clean periodic waveform from the next frame onward. Between strobes the pattern runs on freely with the phases it already holds.

Top module: `clkPatternGen`

## Requirements
- R1: While reset is high, and after reset until the first frame strobe is sampled, every output bit is 0. The phase values used in the frame that follows are the ones present on the setting inputs at that first strobe.
- R2: With phase 0, the output word in the fast cycle right after the clock edge that sampled the strobe carries slots 0 and 1. Slots 0 to 7 are high and slots 8 to 15 are low, so cycles 0 to 3 of the frame show 2'b11 and cycles 4 to 7 show 2'b00.
- R3: With phase p (0 to 15), slot s (0 to 15) of the frame is high exactly when (s - p) mod 16 is less than 8. Each step of p delays the waveform by one half fast cycle.
- R4: In each channel's two-bit word, bit 0 holds the even (earlier) slot 2k and bit 1 holds the odd slot 2k+1 of frame cycle k.
- R5: Channels are independent. Channel c uses bits [4c+3:4c] of the setting bus and drives bits [2c+1:2c] of the output bus, and a change to one channel's setting leaves every other channel's waveform unchanged.
- R6: A setting change between strobes has no effect on the outputs until the next strobe is sampled. The frame then runs on with the phase held since the last strobe.
- R7: A strobe sampled at any frame position, whether early or late, restarts every channel at frame cycle 0 in the following fast cycle.
- R8: Without further strobes, each output word repeats with a period of exactly 8 fast cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkFast | input | 1 | Fast fabric clock, eight cycles per output period |
| rst | input | 1 | Synchronous reset, active high |
| frameStrobe | input | 1 | One-cycle pulse marking the reference clock edge |
| phaseSet | input | 48 | Four-bit phase setting per channel, channel c in bits [4c+3:4c] |
| ddrWord | output | 24 | Two-bit output word per channel, channel c in bits [2c+1:2c] |

## Verification
The bench sweeps every phase value on every channel, with the channels given staggered phases so that each frame mixes different settings. A rotation in the wrong direction, an off-by-one phase, or swapped word halves shows up as a mismatched slot. Settings are changed in the middle of a frame; a design that loads them at once would bend the current frame, producing a runt or a moved edge. Strobes are issued early, late, and not at all for several periods; a counter that ignores the strobe or wraps at the wrong count would lose alignment or change the period. Reset is applied in the middle of a run, to catch outputs that toggle before the first strobe or phases that survive reset.

// File: rtl/clkPatPkg.sv
package clkPatPkg;
  localparam int PHASE_BITS  = 4;
  localparam int SLOT_COUNT  = 1 << PHASE_BITS;
  localparam int CYCLE_COUNT = SLOT_COUNT / 2;
  localparam int IDX_W       = $clog2(CYCLE_COUNT);

  typedef struct packed {
    logic             load;
    logic             run;
    logic [IDX_W-1:0] idx;
  } patStrobe_t;

  // Level of one half-cycle slot for a given delay in slots
  function automatic logic slotLevel(logic [IDX_W-1:0] idx, logic half,
                                     logic [PHASE_BITS-1:0] phase);
    logic [PHASE_BITS-1:0] rel;
    rel = {idx, half} - phase;
    return ~rel[PHASE_BITS-1];
  endfunction
endpackage

// File: rtl/clkPatCtrl.sv
module clkPatCtrl
  import clkPatPkg::*;
(
  input  logic       clkFast,
  input  logic       rst,
  input  logic       frameStrobe,
  output patStrobe_t strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CYCLE_COUNT - 1);

  logic [IDX_W-1:0] idxQ;
  logic             runQ;

  always_comb begin
    strb.load = frameStrobe;
    strb.run  = runQ | frameStrobe;
    if (frameStrobe)
      strb.idx = '0;
    else if (idxQ == LAST_IDX)
      strb.idx = '0;
    else
      strb.idx = idxQ + 1'b1;
  end

  always_ff @(posedge clkFast) begin
    if (rst) begin
      idxQ <= '0;
      runQ <= 1'b0;
    end else begin
      idxQ <= strb.idx;
      runQ <= strb.run;
    end
  end
endmodule

// File: rtl/clkPatData.sv
module clkPatData
  import clkPatPkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                         clkFast,
  input  logic                         rst,
  input  patStrobe_t                   strb,
  input  logic [NUM_CH*PHASE_BITS-1:0] phaseSet,
  output logic [NUM_CH*2-1:0]          ddrWord
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [PHASE_BITS-1:0] phaseQ;
    logic [PHASE_BITS-1:0] phaseNext;
    logic [1:0]            lvl;
    logic [1:0]            wordQ;

    always_comb begin
      phaseNext = strb.load ? phaseSet[ch*PHASE_BITS +: PHASE_BITS] : phaseQ;
      lvl[0]    = slotLevel(strb.idx, 1'b0, phaseNext);
      lvl[1]    = slotLevel(strb.idx, 1'b1, phaseNext);
    end

    always_ff @(posedge clkFast) begin
      if (rst) begin
        phaseQ <= '0;
        wordQ  <= 2'b00;
      end else begin
        phaseQ <= phaseNext;
        wordQ  <= strb.run ? lvl : 2'b00;
      end
    end

    assign ddrWord[ch*2 +: 2] = wordQ;
  end
endmodule

// File: rtl/clkPatternGen.sv
module clkPatternGen
  import clkPatPkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                         clkFast,
  input  logic                         rst,
  input  logic                         frameStrobe,
  input  logic [NUM_CH*PHASE_BITS-1:0] phaseSet,
  output logic [NUM_CH*2-1:0]          ddrWord
);
  patStrobe_t strb;

  clkPatCtrl ctrl_i (
    .clkFast     (clkFast),
    .rst         (rst),
    .frameStrobe (frameStrobe),
    .strb        (strb)
  );

  clkPatData #(.NUM_CH(NUM_CH)) data_i (
    .clkFast  (clkFast),
    .rst      (rst),
    .strb     (strb),
    .phaseSet (phaseSet),
    .ddrWord  (ddrWord)
  );
endmodule

// File: rtl/clkPatternGen_chk.sv
module clkPatternGen_chk
  import clkPatPkg::*;
#(
  parameter int NUM_CH = 12
) (
  input logic                clkFast,
  input logic                rst,
  input logic                frameStrobe,
  input logic [NUM_CH*2-1:0] ddrWord
);
  localparam int CYC   = CYCLE_COUNT;
  localparam int CNT_W = $clog2(CYC + 1);

  logic                armed;
  logic                lastStrobe;
  logic [CNT_W-1:0]    sinceCnt;
  logic [NUM_CH*2-1:0] hist [CYC];

  always_ff @(posedge clkFast) begin
    if (rst) begin
      armed      <= 1'b0;
      lastStrobe <= 1'b0;
      sinceCnt   <= '0;
      for (int i = 0; i < CYC; i++) hist[i] <= '0;
    end else begin
      armed      <= armed | frameStrobe;
      lastStrobe <= frameStrobe;
      if (frameStrobe)
        sinceCnt <= '0;
      else if (sinceCnt != CNT_W'(CYC))
        sinceCnt <= sinceCnt + 1'b1;
      hist[0] <= ddrWord;
      for (int i = 1; i < CYC; i++) hist[i] <= hist[i-1];
    end
  end

  // R1: nothing toggles before the first strobe after reset
  a_r1_idle_low: assert property (@(posedge clkFast) disable iff (rst)
    !armed |-> ddrWord == '0)
    else $error("a_r1_idle_low");

  // R8: a full frame with no strobe repeats the previous one
  a_r8_period_repeat: assert property (@(posedge clkFast) disable iff (rst)
    (armed && sinceCnt >= CNT_W'(CYC)) |-> ddrWord == hist[CYC-1])
    else $error("a_r8_period_repeat");

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    logic [3:0] seq;
    int         edges;
    int         ones;

    always_comb begin
      seq   = {ddrWord[ch*2+1], ddrWord[ch*2], hist[0][ch*2+1], hist[0][ch*2]};
      edges = int'(seq[0] ^ seq[1]) + int'(seq[1] ^ seq[2]) + int'(seq[2] ^ seq[3]);
      ones  = 0;
      for (int i = 0; i < CYC; i++)
        ones = ones + int'(hist[i][ch*2]) + int'(hist[i][ch*2+1]);
    end

    // R3: a 50% wave over 16 slots has at most one edge in any 4 slots
    a_r3_single_edge: assert property (@(posedge clkFast) disable iff (rst)
      (armed && !lastStrobe) |-> edges <= 1)
      else $error("a_r3_single_edge ch%0d", ch);

    // R2: one whole frame holds exactly half high slots
    a_r2_half_duty: assert property (@(posedge clkFast) disable iff (rst)
      (armed && sinceCnt >= CNT_W'(CYC)) |-> ones == CYC)
      else $error("a_r2_half_duty ch%0d", ch);
  end
endmodule

bind clkPatternGen clkPatternGen_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clkFast     (clkFast),
  .rst         (rst),
  .frameStrobe (frameStrobe),
  .ddrWord     (ddrWord)
);

// File: tb/clkPatternGen_tb_top.sv
module clkPatternGen_tb_top;
  localparam int NCH = 12;
  localparam int PW  = 4;
  localparam int CYC = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frameStrobe = 1'b0;
  logic [NCH*PW-1:0] phaseSet = '0;
  logic [NCH*2-1:0]  ddrWord;

  int errors = 0;
  int checks = 0;
  int act [NCH];

  always #10 clk = ~clk;

  clkPatternGen #(.NUM_CH(NCH)) dut_i (
    .clkFast     (clk),
    .rst         (rst),
    .frameStrobe (frameStrobe),
    .phaseSet    (phaseSet),
    .ddrWord     (ddrWord)
  );

  function automatic logic [1:0] expWord(int p, int idx);
    logic [1:0] w;
    for (int b = 0; b < 2; b++) begin
      int s = 2 * idx + b;
      w[b] = ((((s - p) % 16) + 16) % 16) < 8;
    end
    return w;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setPhase(int ch, int p);
    phaseSet[ch*PW +: PW] = PW'(p);
  endtask

  task automatic check(logic [1:0] actual, logic [1:0] expected, string req, int ch);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s ch%0d actual=%b expected=%b", req, ch, actual, expected);
    end
  endtask

  task automatic checkFrame(int idx, string req);
    for (int ch = 0; ch < NCH; ch++)
      check(ddrWord[ch*2 +: 2], expWord(act[ch], idx), req, ch);
  endtask

  task automatic checkZero(string req);
    for (int ch = 0; ch < NCH; ch++)
      check(ddrWord[ch*2 +: 2], 2'b00, req, ch);
  endtask

  task automatic strobeTick();
    frameStrobe = 1'b1;
    for (int ch = 0; ch < NCH; ch++) act[ch] = int'(phaseSet[ch*PW +: PW]);
    tick();
    frameStrobe = 1'b0;
  endtask

  task automatic runFrame(string req);
    strobeTick();
    checkFrame(0, req);
    for (int k = 1; k < CYC; k++) begin
      tick();
      checkFrame(k, req);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: outputs low in reset, a strobe during reset does nothing
    for (int ch = 0; ch < NCH; ch++) setPhase(ch, ch + 2);
    frameStrobe = 1'b1;
    for (int i = 0; i < 3; i++) begin tick(); checkZero("R1"); end
    frameStrobe = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(); checkZero("R1"); end

    // R3 / R5: every phase on every channel, channels staggered
    for (int base = 0; base < 16; base++) begin
      for (int ch = 0; ch < NCH; ch++) setPhase(ch, (base + ch) % 16);
      runFrame("R3");
    end

    // R2: phase 0 gives four high words then four low words
    for (int ch = 0; ch < NCH; ch++) setPhase(ch, 0);
    strobeTick();
    check(ddrWord[1:0], 2'b11, "R2", 0);
    for (int k = 1; k < CYC; k++) begin
      tick();
      check(ddrWord[1:0], (k < 4) ? 2'b11 : 2'b00, "R2", 0);
    end

    // R4: bit 0 is the earlier slot
    setPhase(0, 1);
    setPhase(1, 15);
    strobeTick();
    check(ddrWord[1:0], 2'b10, "R4", 0);
    for (int k = 1; k < 4; k++) tick();
    check(ddrWord[3:2], 2'b01, "R4", 1);
    for (int k = 4; k < CYC; k++) tick();

    // R5: change only channel 3, the rest keep their waveforms
    for (int ch = 0; ch < NCH; ch++) setPhase(ch, 0);
    runFrame("R5");
    setPhase(3, 5);
    runFrame("R5");

    // R6: mid-frame setting change waits for the next strobe
    for (int ch = 0; ch < NCH; ch++) setPhase(ch, (3 * ch) % 16);
    strobeTick();
    checkFrame(0, "R6");
    for (int k = 1; k < CYC; k++) begin
      if (k == 3)
        for (int ch = 0; ch < NCH; ch++) setPhase(ch, (5 * ch + 7) % 16);
      tick();
      checkFrame(k, "R6");
    end
    runFrame("R6");

    // R7: early strobe at frame cycle 4
    strobeTick();
    for (int k = 1; k <= 4; k++) tick();
    for (int ch = 0; ch < NCH; ch++) setPhase(ch, (ch + 9) % 16);
    runFrame("R7");
    // R7: late strobe, 11 cycles after the previous
    strobeTick();
    checkFrame(0, "R7");
    for (int k = 1; k < 11; k++) begin tick(); checkFrame(k % CYC, "R7"); end
    runFrame("R7");

    // R8: free running for three periods without strobe
    strobeTick();
    for (int k = 1; k < 3 * CYC; k++) begin
      tick();
      checkFrame(k % CYC, "R8");
    end

    // R1: reset in the middle of a run
    rst = 1'b1;
    tick();
    checkZero("R1");
    rst = 1'b0;
    for (int ch = 0; ch < NCH; ch++) setPhase(ch, 15 - ch);
    for (int i = 0; i < 4; i++) begin tick(); checkZero("R1"); end
    runFrame("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule